// File: doc/BRIEF.md
# Prescaled Down-Counter Timer

This block is a down-counting timer with a small 32-bit register bus. Software programs a limit, chooses a reload behaviour and a counter width, and enables counting. An external clock-enable tick paces the counter, and a prescaler can slow that tick by a factor of 16 or 256. When the count expires, a sticky raw interrupt flag is set. The flag drives a level interrupt output through an enable bit, and software clears it by writing a dedicated register word.

There are three reload behaviours. A free-running counter wraps to all-ones at the active width. A periodic counter reloads from the stored limit. A one-shot counter parks at zero. Two writes set the limit. The foreground write restarts the count at once. The background write only changes what the next periodic reload will fetch.

Top module: `prog_down_timer`

## Requirements
- R1: After reset, the control register reads 0x20 (only interrupt enable set), Value reads 0, raw status reads 0 and irq_o is low.
- R2: Word address addr_i[4:2] selects the register, and addr_i[1:0] plus any higher bits must be zero. The words are: 0 load (read/write), 1 value (read-only, writes ignored), 2 control (bits [7:0] read back), 3 interrupt clear (write-only, reads 0), 4 raw status (bit 0), 5 masked status (bit 0), 6 background load (read/write).
- R3: The counter takes a step only while control bit 7 (enable) is set. Clearing bit 7 freezes Value.
- R4: Control bits [3:2] pick the prescale. With 01, one step occurs per 16 ticks. With 10, one step occurs per 256 ticks. With 00 or 11, every tick is a step. A write to load or control restarts the prescale phase.
- R5: In periodic mode (control bit 6 set), a step taken at Value 1 (or at 0) reloads the counter from the limit and counts as an expiry.
- R6: In free-running mode (control bit 6 clear), an expiry reloads 0xFFFF when control bit 1 is 0 and 0xFFFFFFFF when bit 1 is 1.
- R7: In one-shot mode (control bit 0 set), a step at Value 1 takes the counter to 0 and counts as an expiry. Further steps leave it at 0 and do not expire again.
- R8: Writing load sets the limit and sets Value to the written data in the next cycle.
- R9: Writing background load changes the limit (read back at word 6) but leaves Value untouched. The new limit is used at the next periodic reload.
- R10: Each expiry sets the raw flag. A write to the clear word clears it. An expiry in the same cycle as a clear wins.
- R11: irq_o and the masked status both equal the raw flag ANDed with control bit 5.
- R12: With control bit 1 clear, only the low 16 bits of the counter are decremented and tested for expiry, and Value reads with bits [31:16] zeroed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Clock-enable tick that paces the prescaler |
| addr_i | input | ADDR_W | Byte address of the register word |
| we_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i (combinational) |
| irq_o | output | 1 | Level interrupt: raw flag AND interrupt enable |

## Verification
The bench walks all three reload behaviours across their expiry boundary. A design that decrements past zero in one-shot mode would read 0xFFFF, and a design that reloads free-running counters from the limit would read the wrong wrap value. It counts exactly 15 and then 255 ticks under the two prescale settings, so an off-by-one divider shows up as an early step. It also checks that a background load leaves the running count alone but is used at the next reload, and that the 16-bit mode hides the upper half of a loaded value. Finally, it raises an expiry in the same cycle as a clear, where a design that lets the clear win would lose the interrupt.

// File: rtl/timer_pkg.sv
package timer_pkg;

  typedef enum logic [2:0] {
    REG_LOAD   = 3'd0,
    REG_VALUE  = 3'd1,
    REG_CTRL   = 3'd2,
    REG_ICLR   = 3'd3,
    REG_RIS    = 3'd4,
    REG_MIS    = 3'd5,
    REG_BGLOAD = 3'd6,
    REG_NONE   = 3'd7
  } reg_sel_e;

  localparam int CTRL_W      = 8;
  localparam int CB_ONESHOT  = 0;
  localparam int CB_WIDE     = 1;
  localparam int CB_PRE_LO   = 2;
  localparam int CB_PRE_HI   = 3;
  localparam int CB_IE       = 5;
  localparam int CB_PERIODIC = 6;
  localparam int CB_EN       = 7;

  localparam logic [CTRL_W-1:0] CTRL_RST = 8'h20;

  localparam int NARROW_W = 16;

endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int DIV_LO_LOG = 4,
  parameter int DIV_HI_LOG = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       clr_i,
  input  logic       tick_i,
  input  logic [1:0] sel_i,
  output logic       step_o
);

  logic [DIV_HI_LOG-1:0] phase_q;
  logic                  wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              phase_q <= '0;
    else if (clr_i)           phase_q <= '0;
    else if (en_i && tick_i)  phase_q <= phase_q + DIV_HI_LOG'(1);
  end

  always_comb begin
    unique case (sel_i)
      2'b01:   wrap = &phase_q[DIV_LO_LOG-1:0];
      2'b10:   wrap = &phase_q;
      default: wrap = 1'b1;
    endcase
  end

  assign step_o = en_i && tick_i && wrap;

endmodule

// File: rtl/timer_counter.sv
module timer_counter
  import timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic [DATA_W-1:0] limit_i,
  input  logic              oneshot_i,
  input  logic              periodic_i,
  input  logic              wide_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              expire_o
);

  localparam int HI_W = DATA_W - NARROW_W;

  logic [DATA_W-1:0] cnt_q, cur, reload_val, dec_val;
  logic              is_zero, is_one;

  assign cur     = wide_i ? cnt_q : {{HI_W{1'b0}}, cnt_q[NARROW_W-1:0]};
  assign is_zero = (cur == '0);
  assign is_one  = (cur == DATA_W'(1));

  // One-shot parks at zero; others expire on a step at 1, or at 0 after a zero load
  assign expire_o = step_i && (is_one || (is_zero && !oneshot_i));

  always_comb begin
    if (oneshot_i)       reload_val = '0;
    else if (periodic_i) reload_val = limit_i;
    else if (wide_i)     reload_val = '1;
    else                 reload_val = {{HI_W{1'b0}}, {NARROW_W{1'b1}}};
  end

  assign dec_val = wide_i ? cnt_q - DATA_W'(1)
                          : {cnt_q[DATA_W-1:NARROW_W], cnt_q[NARROW_W-1:0] - NARROW_W'(1)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (load_i)              cnt_q <= load_val_i;
    else if (expire_o)            cnt_q <= reload_val;
    else if (step_i && !is_zero)  cnt_q <= dec_val;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/timer_regs.sv
module timer_regs
  import timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              expire_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] limit_o,
  output logic              raw_o,
  output logic              load_we_o,
  output logic              ctrl_we_o,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int HI_W = DATA_W - NARROW_W;

  logic              hi_zero, hit;
  reg_sel_e          sel;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] limit_q, value_rd;
  logic              raw_q, clr_we, bg_we;

  generate
    if (ADDR_W > 5) begin : g_hi
      assign hi_zero = ~|addr_i[ADDR_W-1:5];
    end else begin : g_nohi
      assign hi_zero = 1'b1;
    end
  endgenerate

  assign hit = hi_zero && (addr_i[1:0] == 2'b00);
  assign sel = hit ? reg_sel_e'(addr_i[4:2]) : REG_NONE;

  assign load_we_o = we_i && (sel == REG_LOAD);
  assign ctrl_we_o = we_i && (sel == REG_CTRL);
  assign clr_we    = we_i && (sel == REG_ICLR);
  assign bg_we     = we_i && (sel == REG_BGLOAD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= CTRL_RST;
      limit_q <= '0;
      raw_q   <= 1'b0;
    end else begin
      if (ctrl_we_o)            ctrl_q  <= wdata_i[CTRL_W-1:0];
      if (load_we_o || bg_we)   limit_q <= wdata_i;
      if (expire_i)             raw_q   <= 1'b1;
      else if (clr_we)          raw_q   <= 1'b0;
    end
  end

  assign value_rd = ctrl_q[CB_WIDE] ? cnt_i : {{HI_W{1'b0}}, cnt_i[NARROW_W-1:0]};

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      REG_LOAD,
      REG_BGLOAD: rdata_o = limit_q;
      REG_VALUE:  rdata_o = value_rd;
      REG_CTRL:   rdata_o = DATA_W'(ctrl_q);
      REG_RIS:    rdata_o = DATA_W'(raw_q);
      REG_MIS:    rdata_o = DATA_W'(raw_q && ctrl_q[CB_IE]);
      default:    rdata_o = '0;
    endcase
  end

  assign ctrl_o  = ctrl_q;
  assign limit_o = limit_q;
  assign raw_o   = raw_q;

endmodule

// File: rtl/prog_down_timer.sv
module prog_down_timer
  import timer_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 5,
  parameter int DIV_LO_LOG = 4,
  parameter int DIV_HI_LOG = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);

  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] limit_q, cnt_q;
  logic              raw_q, load_we, ctrl_we, step, expire;

  timer_regs #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .we_i      (we_i),
    .wdata_i   (wdata_i),
    .cnt_i     (cnt_q),
    .expire_i  (expire),
    .ctrl_o    (ctrl_q),
    .limit_o   (limit_q),
    .raw_o     (raw_q),
    .load_we_o (load_we),
    .ctrl_we_o (ctrl_we),
    .rdata_o   (rdata_o)
  );

  timer_prescaler #(
    .DIV_LO_LOG (DIV_LO_LOG),
    .DIV_HI_LOG (DIV_HI_LOG)
  ) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctrl_q[CB_EN]),
    .clr_i  (load_we || ctrl_we),
    .tick_i (tick_i),
    .sel_i  (ctrl_q[CB_PRE_HI:CB_PRE_LO]),
    .step_o (step)
  );

  timer_counter #(
    .DATA_W (DATA_W)
  ) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step),
    .load_i     (load_we),
    .load_val_i (wdata_i),
    .limit_i    (limit_q),
    .oneshot_i  (ctrl_q[CB_ONESHOT]),
    .periodic_i (ctrl_q[CB_PERIODIC]),
    .wide_i     (ctrl_q[CB_WIDE]),
    .cnt_o      (cnt_q),
    .expire_o   (expire)
  );

  assign irq_o = raw_q && ctrl_q[CB_IE];

endmodule

// File: rtl/prog_down_timer_chk.sv
module prog_down_timer_chk
  import timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [DATA_W-1:0] cnt_q,
  input logic              raw_q,
  input logic              step,
  input logic              expire
);

  localparam int HI_W = DATA_W - NARROW_W;

  logic              wr_load, wr_ctrl, wr_clr, wr_bg;
  logic [DATA_W-1:0] vis;

  assign wr_load = we_i && (addr_i == ADDR_W'({REG_LOAD,   2'b00}));
  assign wr_ctrl = we_i && (addr_i == ADDR_W'({REG_CTRL,   2'b00}));
  assign wr_clr  = we_i && (addr_i == ADDR_W'({REG_ICLR,   2'b00}));
  assign wr_bg   = we_i && (addr_i == ADDR_W'({REG_BGLOAD, 2'b00}));
  assign vis     = ctrl_q[CB_WIDE] ? cnt_q : {{HI_W{1'b0}}, cnt_q[NARROW_W-1:0]};

  p_load_sets_count_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_load |=> cnt_q == $past(wdata_i));

  p_frozen_when_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q[CB_EN] && !wr_load) |=> $stable(cnt_q));

  p_oneshot_parks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[CB_ONESHOT] && vis == '0 && !wr_load && !wr_ctrl) |=> vis == '0);

  p_oneshot_no_refire_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[CB_ONESHOT] && vis == '0) |-> !expire);

  p_bg_keeps_count_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_bg && !step) |=> $stable(cnt_q));

  p_expire_sets_raw_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> raw_q);

  p_clear_drops_raw_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_clr && !expire) |=> !raw_q);

endmodule

bind prog_down_timer prog_down_timer_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (.*);

// File: tb/prog_down_timer_tb_top.sv
`timescale 1ns/1ps
module prog_down_timer_tb_top;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2, OP_IRQ = 2'd3;
  localparam logic [4:0] A_LOAD = 5'h00, A_VAL = 5'h04, A_CTRL = 5'h08, A_CLR = 5'h0C,
                         A_RIS = 5'h10, A_MIS = 5'h14, A_BG = 5'h18;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  req;
    logic [4:0]  addr;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 56;
  localparam vec_t VEC [NV] = '{
    // R8 load while disabled, R3 no counting while off
    '{OP_WR, 4'd8,  A_LOAD, 32'd5},
    '{OP_RD, 4'd8,  A_VAL,  32'd5},
    '{OP_TK, 4'd3,  A_VAL,  32'd4},
    '{OP_RD, 4'd3,  A_VAL,  32'd5},
    // R5 periodic 32-bit
    '{OP_WR, 4'd5,  A_CTRL, 32'hE2},
    '{OP_RD, 4'd2,  A_CTRL, 32'hE2},
    '{OP_TK, 4'd5,  A_VAL,  32'd3},
    '{OP_RD, 4'd5,  A_VAL,  32'd2},
    '{OP_TK, 4'd5,  A_VAL,  32'd2},
    '{OP_RD, 4'd5,  A_VAL,  32'd5},
    '{OP_RD, 4'd10, A_RIS,  32'd1},
    '{OP_IRQ,4'd11, A_VAL,  32'd1},   // R11
    '{OP_RD, 4'd11, A_MIS,  32'd1},
    '{OP_WR, 4'd10, A_CLR,  32'd0},
    '{OP_RD, 4'd10, A_RIS,  32'd0},
    '{OP_IRQ,4'd11, A_VAL,  32'd0},
    // R9 background load
    '{OP_WR, 4'd9,  A_BG,   32'd3},
    '{OP_RD, 4'd9,  A_VAL,  32'd5},
    '{OP_TK, 4'd9,  A_VAL,  32'd5},
    '{OP_RD, 4'd9,  A_VAL,  32'd3},
    '{OP_RD, 4'd5,  A_RIS,  32'd1},
    '{OP_WR, 4'd10, A_CLR,  32'd0},
    // R6 free-running 16-bit, R12 narrow view
    '{OP_WR, 4'd6,  A_CTRL, 32'hA0},
    '{OP_WR, 4'd6,  A_LOAD, 32'd2},
    '{OP_TK, 4'd6,  A_VAL,  32'd2},
    '{OP_RD, 4'd6,  A_VAL,  32'h0000FFFF},
    '{OP_RD, 4'd6,  A_RIS,  32'd1},
    '{OP_WR, 4'd12, A_LOAD, 32'h00012345},
    '{OP_RD, 4'd12, A_VAL,  32'h00002345},
    '{OP_TK, 4'd12, A_VAL,  32'd1},
    '{OP_RD, 4'd12, A_VAL,  32'h00002344},
    '{OP_WR, 4'd10, A_CLR,  32'd0},
    // R6 free-running 32-bit
    '{OP_WR, 4'd6,  A_CTRL, 32'hA2},
    '{OP_WR, 4'd6,  A_LOAD, 32'd1},
    '{OP_TK, 4'd6,  A_VAL,  32'd1},
    '{OP_RD, 4'd6,  A_VAL,  32'hFFFFFFFF},
    '{OP_WR, 4'd10, A_CLR,  32'd0},
    // R7 one-shot
    '{OP_WR, 4'd7,  A_CTRL, 32'hA1},
    '{OP_WR, 4'd7,  A_LOAD, 32'd3},
    '{OP_TK, 4'd7,  A_VAL,  32'd3},
    '{OP_RD, 4'd7,  A_VAL,  32'd0},
    '{OP_RD, 4'd7,  A_RIS,  32'd1},
    '{OP_WR, 4'd10, A_CLR,  32'd0},
    '{OP_TK, 4'd7,  A_VAL,  32'd4},
    '{OP_RD, 4'd7,  A_VAL,  32'd0},
    '{OP_RD, 4'd7,  A_RIS,  32'd0},
    // R11 masking by interrupt enable
    '{OP_WR, 4'd11, A_CTRL, 32'h81},
    '{OP_WR, 4'd11, A_LOAD, 32'd1},
    '{OP_TK, 4'd11, A_VAL,  32'd1},
    '{OP_RD, 4'd11, A_RIS,  32'd1},
    '{OP_RD, 4'd11, A_MIS,  32'd0},
    '{OP_IRQ,4'd11, A_VAL,  32'd0},
    '{OP_WR, 4'd11, A_CTRL, 32'hA1},
    '{OP_RD, 4'd11, A_MIS,  32'd1},
    '{OP_IRQ,4'd11, A_VAL,  32'd1},
    '{OP_WR, 4'd10, A_CLR,  32'd0}
  };

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              tick_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              we_i = 1'b0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [DATA_W-1:0] rdata_o;
  logic              irq_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  prog_down_timer dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .addr_i  (addr_i),
    .we_i    (we_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o)
  );

  task automatic check(input int req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk);
    we_i = 1'b0;
  endtask

  task automatic read_check(input int req, input logic [4:0] a, input logic [31:0] exp);
    addr_i = a;
    #1;
    check(req, $sformatf("read @%h", a), rdata_o, exp);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick_i = 1'b1;
    end
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    read_check(1, A_CTRL, 32'h20);
    read_check(1, A_VAL, 32'd0);
    read_check(1, A_RIS, 32'd0);
    check(1, "irq at reset", 32'(irq_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      unique case (VEC[i].op)
        OP_WR:  bus_write(VEC[i].addr, VEC[i].data);
        OP_RD:  read_check(int'(VEC[i].req), VEC[i].addr, VEC[i].data);
        OP_TK:  ticks(int'(VEC[i].data));
        default: begin
          #1;
          check(int'(VEC[i].req), "irq_o", 32'(irq_o), VEC[i].data);
        end
      endcase
    end

    // R4 divide by 16
    bus_write(A_CTRL, 32'hE6);
    bus_write(A_LOAD, 32'd10);
    ticks(15);
    read_check(4, A_VAL, 32'd10);
    ticks(1);
    read_check(4, A_VAL, 32'd9);
    // R4 divide by 256
    bus_write(A_CTRL, 32'hEA);
    bus_write(A_LOAD, 32'd10);
    ticks(255);
    read_check(4, A_VAL, 32'd10);
    ticks(1);
    read_check(4, A_VAL, 32'd9);
    // R4 code 11 means no division
    bus_write(A_CTRL, 32'hEE);
    bus_write(A_LOAD, 32'd10);
    ticks(1);
    read_check(4, A_VAL, 32'd9);

    // R3 disabling freezes the count
    bus_write(A_CTRL, 32'h62);
    read_check(3, A_CTRL, 32'h62);
    ticks(5);
    read_check(3, A_VAL, 32'd9);

    // R2 value word ignores writes, clear word reads zero
    bus_write(A_VAL, 32'h55);
    read_check(2, A_VAL, 32'd9);
    read_check(2, A_CLR, 32'd0);

    // R10 expiry beats a clear in the same cycle
    bus_write(A_CTRL, 32'hE2);
    bus_write(A_LOAD, 32'd1);
    @(negedge clk);
    tick_i = 1'b1; addr_i = A_CLR; we_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0; we_i = 1'b0;
    read_check(10, A_RIS, 32'd1);
    bus_write(A_CLR, 32'd0);
    read_check(10, A_RIS, 32'd0);

    // R1 reset returns to defaults mid-run
    bus_write(A_LOAD, 32'd7);
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    read_check(1, A_CTRL, 32'h20);
    read_check(1, A_VAL, 32'd0);
    rst_ni = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule